// File: doc/BRIEF.md
# External Memory Bus Controller

This block is the master side of an asynchronous-style external memory bus. A single internal request port issues byte reads, byte writes, word reads, word writes and instruction-fetch bursts. The controller turns each request into one or more bus cycles. Each cycle drives a 20-bit address, a chip select, an output enable for reads, and low and high byte strobes. During writes it also drives a data bus with a separate drive enable. A WAIT input lets a slow device stretch the strobe phase. The width of the external data bus is chosen per request by the `cfg_bus16` pin: 16 bits when it is high, 8 bits when it is low. The pin is sampled when the request is accepted.

Every bus cycle (a "beat") walks the states ST_IDLE → ST_SETUP → ST_STROBE → (ST_WAITX) → ST_HOLD. ST_IDLE accepts a request and moves to ST_SETUP. ST_SETUP drives the address (and the write data) for `SETUP_CYC` cycles and then moves to ST_STROBE. ST_STROBE holds the strobes low for `STROBE_CYC` cycles. On its last cycle it goes to ST_WAITX if WAIT is high, and to ST_HOLD otherwise. ST_WAITX stays put while WAIT is high and moves to ST_HOLD once WAIT is low. ST_HOLD raises the strobes for `HOLD_CYC` cycles. It then returns to ST_SETUP if beats remain, and to ST_IDLE after the last beat. A request with an illegal burst length goes from ST_IDLE back to ST_IDLE, with an error pulse and no bus cycle.

A word access on the 8-bit bus runs as two byte beats, low byte first. A fetch burst runs one beat per bus-width unit and steps only the low address bits. Read data is sampled on the clock edge that ends the strobe phase.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, and whenever the controller is in ST_IDLE, `bus_cs_n`, `bus_oe_n`, `bus_ble_n` and `bus_bhe_n` are high (inactive), `bus_dout_en` is low and `req_ready` is high. A request is taken on a rising edge where `req_valid` and `req_ready` are both high.
- R2: The beat address is on `bus_addr` for at least one full cycle before `bus_cs_n` falls. It does not change while `bus_cs_n` is low.
- R3: On the 16-bit bus, a word access or a fetch drives both byte strobes low, with `bus_addr[0]` forced to 0. A byte access drives only `bus_ble_n` low when address bit 0 is 0, and only `bus_bhe_n` low when it is 1. Byte-write data appears on both lanes (`{wdata[7:0],wdata[7:0]}`). A byte read returns the selected lane in `rsp_rdata[7:0]`, with the upper byte 0.
- R4: On the 8-bit bus, `bus_ble_n` goes low for every beat, whether the address is odd or even, and `bus_bhe_n` never goes low. Data travels on bit lanes 7:0 only: `bus_din[15:8]` is ignored and `bus_dout[15:8]` is 0.
- R5: On the 8-bit bus, a word access is split into two beats, at `{addr[19:1],0}` and then at `{addr[19:1],1}`. The low byte (`wdata[7:0]`, or read into `rsp_rdata[7:0]`) goes first. A single `rsp_done` follows the second beat.
- R6: A fetch (`req_fetch`=1) with burst length `req_blen` (in bytes) runs `req_blen/2` beats on the 16-bit bus and `req_blen` beats on the 8-bit bus. It pulses `rsp_beat` once per beat, with that beat's data on `rsp_rdata`: the whole 16-bit word, or `{8'h00, byte}` on the 8-bit bus.
- R7: For fetch beat i, bits 19:4 keep the request's value. On the 16-bit bus, bits 3:1 are `(addr[3:1]+i) mod 8` and bit 0 is 0. On the 8-bit bus, bits 3:0 are `(addr[3:0]+i) mod 16`.
- R8: A fetch whose `req_blen` is below 2, above 16, or odd on the 16-bit bus is rejected. `rsp_err` pulses for one cycle, no strobe goes low and no `rsp_done` is raised.
- R9: The strobes of a beat stay low for `STROBE_CYC` cycles, plus one cycle for each consecutive rising edge, starting with the one that ends the last ST_STROBE cycle, at which WAIT is high. WAIT sampled at any other time has no effect.
- R10: Read data is sampled on the rising edge at which the strobes are released. After the strobes rise on a read, `bus_addr[19:1]` stays unchanged for the ST_HOLD cycles.
- R11: `bus_dout_en` is never high while `bus_oe_n` is low. It rises only when `bus_oe_n` was already high in the previous cycle.
- R12: On a write beat, `bus_dout` is valid and `bus_dout_en` is high from ST_SETUP onwards, so before the strobes fall. Both stay unchanged for the ST_HOLD cycle after the strobes rise.
- R13: `rsp_done` is a single-cycle pulse, raised in the cycle after the last beat's ST_HOLD. It is never raised together with `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the bus reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus16 | input | 1 | 1: 16-bit data bus, 0: 8-bit; sampled at request accept |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1: write, 0: read |
| req_word | input | 1 | 1: 16-bit access, 0: byte |
| req_fetch | input | 1 | Instruction-fetch burst (read only) |
| req_blen | input | BLEN_W | Burst length in bytes for fetches |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data (with rsp_done) or fetch beat data (with rsp_beat) |
| rsp_beat | output | 1 | Fetch beat data valid |
| rsp_done | output | 1 | Request complete |
| rsp_err | output | 1 | Request rejected |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable (reads), active low |
| bus_ble_n | output | 1 | Low byte strobe, active low |
| bus_bhe_n | output | 1 | High byte strobe, active low |
| bus_dout | output | 16 | Write data to the bus |
| bus_dout_en | output | 1 | Write data driver enable |
| bus_din | input | 16 | Read data from the bus |
| bus_wait | input | 1 | Wait request from the device |

## Verification
A stuck or skipped state shows up within one beat as a wrong strobe low time, a missing beat or a missing `rsp_done`. The bench measures every beat's strobe length against the WAIT pattern it drives. A wrong beat index or lane choice shows on the next strobe as a wrong address, a wrong strobe pair or misplaced write data. It also shows at `rsp_done` as misassembled read data, because the bench's memory model returns address-dependent bytes. Setup, hold and driver turnaround faults are visible on the edge where `bus_cs_n` changes.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_WAITX,
        ST_HOLD
    } ebc_state_t;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/ebc_phase_timer.sv
module ebc_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (!at_last) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == limit - 1'b1);
endmodule

// File: rtl/ebc_lane_map.sv
module ebc_lane_map import ebc_pkg::*; #(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 5
) (
    input  logic              bus16,
    input  logic              is_fetch,
    input  logic              is_word,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BUS_W-1:0]  wdata,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              ble_n,
    output logic              bhe_n,
    output logic [BUS_W-1:0]  lane_wdata
);
    logic [2:0] word_step;
    logic [3:0] byte_step;

    always_comb begin
        word_step = base[3:1] + idx[2:0];
        byte_step = base[3:0] + idx[3:0];
        if (is_fetch) begin
            beat_addr = bus16 ? {base[ADDR_W-1:4], word_step, 1'b0}
                              : {base[ADDR_W-1:4], byte_step};
        end else if (is_word) begin
            beat_addr = bus16 ? {base[ADDR_W-1:1], 1'b0}
                              : {base[ADDR_W-1:1], idx[0]};
        end else begin
            beat_addr = base;
        end
    end

    always_comb begin
        if (!bus16) begin
            ble_n = 1'b0;
            bhe_n = 1'b1;
        end else if (is_fetch || is_word) begin
            ble_n = 1'b0;
            bhe_n = 1'b0;
        end else begin
            ble_n = beat_addr[0];
            bhe_n = !beat_addr[0];
        end
    end

    always_comb begin
        if (bus16) begin
            lane_wdata = is_word ? wdata : {wdata[BYTE_W-1:0], wdata[BYTE_W-1:0]};
        end else begin
            lane_wdata = {{BYTE_W{1'b0}},
                          (is_word && idx[0]) ? wdata[BUS_W-1:BYTE_W] : wdata[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/ebc_rd_merge.sv
module ebc_rd_merge import ebc_pkg::*; (
    input  logic             bus16,
    input  logic             is_fetch,
    input  logic             is_word,
    input  logic             addr0,
    input  logic             idx0,
    input  logic [BUS_W-1:0] din,
    input  logic [BUS_W-1:0] cur,
    output logic [BUS_W-1:0] merged
);
    localparam logic [BYTE_W-1:0] ZB = '0;

    always_comb begin
        if (is_fetch) begin
            merged = bus16 ? din : {ZB, din[BYTE_W-1:0]};
        end else if (bus16) begin
            if (is_word)
                merged = din;
            else
                merged = {ZB, addr0 ? din[BUS_W-1:BYTE_W] : din[BYTE_W-1:0]};
        end else if (is_word && idx0) begin
            merged = {din[BYTE_W-1:0], cur[BYTE_W-1:0]};
        end else begin
            merged = {ZB, din[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl import ebc_pkg::*; #(
    parameter int ADDR_W     = 20,
    parameter int BLEN_W     = 5,
    parameter int MAX_BURST  = 16,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bus16,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_word,
    input  logic              req_fetch,
    input  logic [BLEN_W-1:0] req_blen,
    input  logic [15:0]       req_wdata,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_beat,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_oe_n,
    output logic              bus_ble_n,
    output logic              bus_bhe_n,
    output logic [15:0]       bus_dout,
    output logic              bus_dout_en,
    input  logic [15:0]       bus_din,
    input  logic              bus_wait
);
    localparam int LONG1   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int LONGEST = (LONG1 > HOLD_CYC) ? LONG1 : HOLD_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int IDX_W   = BLEN_W;

    ebc_state_t state, nxt;

    logic              r_write, r_word, r_fetch, r_bus16;
    logic [ADDR_W-1:0] r_addr;
    logic [BUS_W-1:0]  r_wdata;
    logic [IDX_W-1:0]  r_nbeats, beat_idx, nxt_idx, nbeats_c;
    logic              pend_ble_n, pend_bhe_n;

    logic              accepting, req_bad, at_last, last_beat, capture, strobing;
    logic [CNT_W-1:0]  limit;

    logic              cur_write, cur_word, cur_fetch, cur_bus16;
    logic [ADDR_W-1:0] cur_addr;
    logic [BUS_W-1:0]  cur_wdata;

    logic [ADDR_W-1:0] lm_addr;
    logic              lm_ble_n, lm_bhe_n;
    logic [BUS_W-1:0]  lm_wdata, rd_merged;

    assign accepting = (state == ST_IDLE);
    assign req_ready = accepting;

    assign req_bad = req_fetch &&
                     ((req_blen < BLEN_W'(2)) ||
                      (req_blen > BLEN_W'(MAX_BURST)) ||
                      (cfg_bus16 && req_blen[0]));

    always_comb begin
        if (req_fetch)
            nbeats_c = cfg_bus16 ? {1'b0, req_blen[BLEN_W-1:1]} : req_blen;
        else if (req_word && !cfg_bus16)
            nbeats_c = IDX_W'(2);
        else
            nbeats_c = IDX_W'(1);
    end

    always_comb begin
        cur_write = accepting ? req_write : r_write;
        cur_word  = accepting ? req_word  : r_word;
        cur_fetch = accepting ? req_fetch : r_fetch;
        cur_bus16 = accepting ? cfg_bus16 : r_bus16;
        cur_addr  = accepting ? req_addr  : r_addr;
        cur_wdata = accepting ? req_wdata : r_wdata;
        nxt_idx   = accepting ? '0 : beat_idx + 1'b1;
    end

    always_comb begin
        unique case (state)
            ST_SETUP:  limit = CNT_W'(SETUP_CYC);
            ST_STROBE: limit = CNT_W'(STROBE_CYC);
            ST_HOLD:   limit = CNT_W'(HOLD_CYC);
            default:   limit = CNT_W'(1);
        endcase
    end

    ebc_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (nxt != state),
        .limit   (limit),
        .at_last (at_last)
    );

    ebc_lane_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) lane_i (
        .bus16      (cur_bus16),
        .is_fetch   (cur_fetch),
        .is_word    (cur_word),
        .base       (cur_addr),
        .idx        (nxt_idx),
        .wdata      (cur_wdata),
        .beat_addr  (lm_addr),
        .ble_n      (lm_ble_n),
        .bhe_n      (lm_bhe_n),
        .lane_wdata (lm_wdata)
    );

    ebc_rd_merge merge_i (
        .bus16    (r_bus16),
        .is_fetch (r_fetch),
        .is_word  (r_word),
        .addr0    (r_addr[0]),
        .idx0     (beat_idx[0]),
        .din      (bus_din),
        .cur      (rsp_rdata),
        .merged   (rd_merged)
    );

    assign last_beat = (beat_idx == r_nbeats - 1'b1);
    assign capture   = ((state == ST_STROBE && at_last) || state == ST_WAITX) && !bus_wait;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid && !req_bad) nxt = ST_SETUP;
            ST_SETUP:  if (at_last) nxt = ST_STROBE;
            ST_STROBE: if (at_last) nxt = bus_wait ? ST_WAITX : ST_HOLD;
            ST_WAITX:  if (!bus_wait) nxt = ST_HOLD;
            ST_HOLD:   if (at_last) nxt = last_beat ? ST_IDLE : ST_SETUP;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign strobing = (nxt == ST_STROBE) || (nxt == ST_WAITX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_write     <= 1'b0;
            r_word      <= 1'b0;
            r_fetch     <= 1'b0;
            r_bus16     <= 1'b0;
            r_addr      <= '0;
            r_wdata     <= '0;
            r_nbeats    <= '0;
            beat_idx    <= '0;
            pend_ble_n  <= 1'b1;
            pend_bhe_n  <= 1'b1;
            bus_addr    <= '0;
            bus_dout    <= '0;
            bus_cs_n    <= 1'b1;
            bus_oe_n    <= 1'b1;
            bus_ble_n   <= 1'b1;
            bus_bhe_n   <= 1'b1;
            bus_dout_en <= 1'b0;
            rsp_rdata   <= '0;
            rsp_beat    <= 1'b0;
            rsp_done    <= 1'b0;
            rsp_err     <= 1'b0;
        end else begin
            if (accepting && req_valid && !req_bad) begin
                r_write  <= req_write;
                r_word   <= req_word;
                r_fetch  <= req_fetch;
                r_bus16  <= cfg_bus16;
                r_addr   <= req_addr;
                r_wdata  <= req_wdata;
                r_nbeats <= nbeats_c;
            end
            if (nxt == ST_SETUP && state != ST_SETUP) begin
                beat_idx   <= nxt_idx;
                bus_addr   <= lm_addr;
                bus_dout   <= lm_wdata;
                pend_ble_n <= lm_ble_n;
                pend_bhe_n <= lm_bhe_n;
            end
            bus_cs_n    <= !strobing;
            bus_oe_n    <= !(strobing && !cur_write);
            bus_ble_n   <= strobing ? pend_ble_n : 1'b1;
            bus_bhe_n   <= strobing ? pend_bhe_n : 1'b1;
            bus_dout_en <= cur_write && (nxt != ST_IDLE);
            if (capture) rsp_rdata <= rd_merged;
            rsp_beat <= capture && r_fetch;
            rsp_done <= (state == ST_HOLD) && at_last && last_beat;
            rsp_err  <= accepting && req_valid && req_bad;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (bus_cs_n && bus_oe_n && bus_ble_n && bus_bhe_n && !bus_dout_en));
    // R2
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> $stable(bus_addr));
    // R2
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));
    // R4
    narrow_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_bus16 && !bus_cs_n) |-> bus_bhe_n);
    // R8
    err_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (bus_cs_n && !rsp_done));
    // R9
    wait_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITX && bus_wait) |=> !bus_cs_n);
    // R10
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> $stable(bus_addr[ADDR_W-1:1]));
    // R11
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> !bus_dout_en);
    // R11
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> $past(bus_oe_n));
    // R12
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_cs_n) && bus_dout_en) |-> ($past(bus_dout_en) && $stable(bus_dout)));
    // R12
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_cs_n) && $past(bus_dout_en)) |-> (bus_dout_en && $stable(bus_dout)));
    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

// File: tb/ext_bus_ctrl_tb.sv
`timescale 1ns/1ps
module ext_bus_ctrl_tb_top;
    localparam int STROBE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus16 = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0, req_word = 1'b0, req_fetch = 1'b0;
    logic [4:0]  req_blen = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_beat, rsp_done, rsp_err;
    logic [19:0] bus_addr;
    logic        bus_cs_n, bus_oe_n, bus_ble_n, bus_bhe_n, bus_dout_en;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_wait = 1'b0;

    int n_checks = 0, n_err = 0;
    bit finished = 0;

    // bus monitor records
    int          nb = 0, lowcnt = 0, wait_n = 0, fights = 0;
    logic [19:0] b_addr [32];
    logic        b_ble [32], b_bhe [32], b_oe [32], b_den [32], b_setup_ok [32], b_hden [32];
    logic [15:0] b_dout [32], b_hdout [32];
    logic [19:0] b_haddr [32];
    int          b_len [32];
    logic [15:0] f_data [32];
    int          fcnt = 0;

    ext_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_word(req_word), .req_fetch(req_fetch),
        .req_blen(req_blen), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_beat(rsp_beat), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
        .bus_ble_n(bus_ble_n), .bus_bhe_n(bus_bhe_n), .bus_dout(bus_dout),
        .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_wait(bus_wait)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] mem(input logic [19:0] a);
        logic [19:0] t;
        t = a * 20'd13 + (a >> 8);
        return t[7:0] ^ 8'h3C;
    endfunction

    function automatic int exp_beats(input bit b16, input bit wd, input bit fe, input logic [4:0] bl);
        if (fe) return b16 ? int'(bl) / 2 : int'(bl);
        return (wd && !b16) ? 2 : 1;
    endfunction

    function automatic logic [19:0] exp_addr(input bit b16, input bit wd, input bit fe,
                                             input logic [19:0] a, input int i);
        logic [2:0] w3;
        logic [3:0] b4;
        w3 = a[3:1] + 3'(i);
        b4 = a[3:0] + 4'(i);
        if (fe) return b16 ? {a[19:4], w3, 1'b0} : {a[19:4], b4};
        if (wd) return b16 ? {a[19:1], 1'b0} : {a[19:1], 1'(i)};
        return a;
    endfunction

    function automatic logic [15:0] exp_dout(input bit b16, input bit wd, input logic [15:0] w, input int i);
        if (b16) return wd ? w : {w[7:0], w[7:0]};
        return {8'h00, (wd && i == 1) ? w[15:8] : w[7:0]};
    endfunction

    function automatic logic [15:0] exp_rd(input bit b16, input bit wd, input logic [19:0] a);
        if (wd) return {mem({a[19:1], 1'b1}), mem({a[19:1], 1'b0})};
        return {8'h00, mem(a)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus device model and monitor
    initial begin
        logic [19:0] p_addr;
        logic        p_cs, p_oe, p_den;
        logic [15:0] p_dout;
        p_addr = '0; p_cs = 1; p_oe = 1; p_den = 0; p_dout = '0;
        forever begin
            @(negedge clk);
            if (!bus_cs_n) begin
                if (lowcnt == 0 && nb < 32) begin
                    b_addr[nb] = bus_addr; b_ble[nb] = bus_ble_n; b_bhe[nb] = bus_bhe_n;
                    b_oe[nb] = bus_oe_n; b_den[nb] = bus_dout_en; b_dout[nb] = bus_dout;
                    b_setup_ok[nb] = p_cs && (p_addr == bus_addr) &&
                                     (!bus_dout_en || (p_den && p_dout == bus_dout));
                end
                lowcnt++;
            end else if (lowcnt != 0) begin
                if (nb < 32) begin
                    b_len[nb] = lowcnt; b_haddr[nb] = bus_addr;
                    b_hden[nb] = bus_dout_en; b_hdout[nb] = bus_dout;
                end
                nb++;
                lowcnt = 0;
            end
            if (bus_dout_en && (!bus_oe_n || !p_oe)) fights++;
            if (!bus_oe_n)
                bus_din = cfg_bus16 ? {mem({bus_addr[19:1], 1'b1}), mem({bus_addr[19:1], 1'b0})}
                                    : {8'h5A, mem(bus_addr)};
            else
                bus_din = 16'hDEAD;
            if (!bus_cs_n) bus_wait = (lowcnt < STROBE + wait_n);
            else           bus_wait = 1'($urandom % 2);
            p_addr = bus_addr; p_cs = bus_cs_n; p_oe = bus_oe_n; p_den = bus_dout_en; p_dout = bus_dout;
        end
    end

    task automatic run_txn(input bit b16, input bit wr, input bit wd, input bit fe,
                           input logic [4:0] bl, input logic [19:0] ad, input logic [15:0] wv,
                           input int nw);
        int t, nbx;
        bit bad;
        string lt;
        cfg_bus16 = b16; wait_n = nw; nb = 0; fcnt = 0;
        req_addr = ad; req_write = wr && !fe; req_word = wd; req_fetch = fe;
        req_blen = bl; req_wdata = wv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!(rsp_done || rsp_err) && t < 3000) begin
            if (rsp_beat && fcnt < 32) begin f_data[fcnt] = rsp_rdata; fcnt++; end
            @(negedge clk);
            t++;
        end
        bad = fe && (bl < 2 || bl > 16 || (b16 && bl[0]));
        // R8: rejection flag and no bus activity
        chk(rsp_err == bad, "R8 err", 32'(rsp_err), 32'(bad));
        if (bad) begin
            chk(nb == 0, "R8 no beats", 32'(nb), 0);
        end else begin
            nbx = exp_beats(b16, wd, fe, bl);
            chk(rsp_done == 1'b1, "R13 done", 32'(rsp_done), 1);
            chk(nb == nbx, fe ? "R6 beats" : "R5 beats", 32'(nb), 32'(nbx));
            lt = fe ? "R7" : (!b16 ? (wd ? "R5" : "R4") : "R3");
            for (int i = 0; i < nbx && i < nb; i++) begin
                logic [19:0] ea;
                bit eb, eh;
                ea = exp_addr(b16, wd, fe, ad, i);
                eb = b16 ? ((fe || wd) ? 1'b0 : ea[0]) : 1'b0;
                eh = b16 ? ((fe || wd) ? 1'b0 : !ea[0]) : 1'b1;
                chk(b_addr[i] == ea, {lt, " addr"}, 32'(b_addr[i]), 32'(ea));
                chk(b_ble[i] == eb && b_bhe[i] == eh, b16 ? "R3 strobes" : "R4 strobes",
                    {30'd0, b_bhe[i], b_ble[i]}, {30'd0, eh, eb});
                chk(b_oe[i] == (wr && !fe), "R11 oe", 32'(b_oe[i]), 32'(wr && !fe));
                chk(b_len[i] == STROBE + nw, "R9 strobe len", 32'(b_len[i]), 32'(STROBE + nw));
                chk(b_setup_ok[i], "R2 setup", 32'(b_setup_ok[i]), 1);
                if (wr && !fe) begin
                    chk(b_den[i] && b_dout[i] == exp_dout(b16, wd, wv, i), "R12 wdata",
                        32'(b_dout[i]), 32'(exp_dout(b16, wd, wv, i)));
                    chk(b_hden[i] && b_hdout[i] == b_dout[i], "R12 hold",
                        32'(b_hdout[i]), 32'(b_dout[i]));
                end else if (!fe) begin
                    chk(b_haddr[i][19:1] == ea[19:1], "R10 addr hold",
                        32'(b_haddr[i]), 32'(ea));
                end
            end
            if (fe) begin
                chk(fcnt == nbx, "R6 beat pulses", 32'(fcnt), 32'(nbx));
                for (int i = 0; i < nbx && i < fcnt; i++) begin
                    logic [19:0] ba;
                    logic [15:0] ed;
                    ba = exp_addr(b16, 1'b0, 1'b1, ad, i);
                    ed = b16 ? {mem(ba | 20'd1), mem(ba)} : {8'h00, mem(ba)};
                    chk(f_data[i] == ed, "R6 fetch data", 32'(f_data[i]), 32'(ed));
                end
            end else if (!wr) begin
                chk(rsp_rdata == exp_rd(b16, wd, ad), {lt, " rdata"},
                    32'(rsp_rdata), 32'(exp_rd(b16, wd, ad)));
            end
        end
        @(negedge clk);
        chk(!rsp_done && !rsp_err && req_ready, "R13 single pulse",
            {29'd0, req_ready, rsp_err, rsp_done}, 32'h4);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_cs_n && bus_oe_n && bus_ble_n && bus_bhe_n && !bus_dout_en && !rsp_done,
            "R1 reset outputs", {26'd0, bus_cs_n, bus_oe_n, bus_ble_n, bus_bhe_n, bus_dout_en, rsp_done}, 32'h3C);
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // directed: 16-bit bus
        run_txn(1, 1, 1, 0, 0, 20'h12345, 16'hBEEF, 0);   // R3 word write
        run_txn(1, 0, 1, 0, 0, 20'h12344, 16'h0, 0);      // R3 word read, R11 turnaround
        run_txn(1, 1, 0, 0, 0, 20'h00011, 16'h00A7, 1);   // R3 high byte write
        run_txn(1, 0, 0, 0, 0, 20'h00011, 16'h0, 0);      // R3 high byte read
        run_txn(1, 0, 0, 0, 0, 20'h00010, 16'h0, 3);      // R9 long wait
        run_txn(1, 0, 0, 1, 16, 20'hABCDA, 16'h0, 0);     // R7 wrap of low bits
        run_txn(1, 0, 0, 1, 2, 20'h0000E, 16'h0, 1);      // R6 shortest burst
        // directed: 8-bit bus
        run_txn(0, 1, 1, 0, 0, 20'h00101, 16'h1234, 0);   // R5 word write split
        run_txn(0, 0, 1, 0, 0, 20'h00100, 16'h0, 2);      // R5 word read split
        run_txn(0, 0, 0, 0, 0, 20'h00103, 16'h0, 0);      // R4 odd byte
        run_txn(0, 1, 0, 0, 0, 20'h00102, 16'h00C3, 0);   // R4 even byte write
        run_txn(0, 0, 0, 1, 16, 20'h0F0F7, 16'h0, 0);     // R7 8-bit wrap
        // R8 rejections
        run_txn(1, 0, 0, 1, 0, 20'h1, 16'h0, 0);
        run_txn(0, 0, 0, 1, 1, 20'h1, 16'h0, 0);
        run_txn(0, 0, 0, 1, 17, 20'h1, 16'h0, 0);
        run_txn(1, 0, 0, 1, 3, 20'h1, 16'h0, 0);
        // random mix
        for (int k = 0; k < 300; k++) begin
            bit b16, wr, wd, fe;
            logic [4:0] bl;
            b16 = 1'($urandom % 2);
            fe  = ($urandom % 4) == 0;
            wr  = 1'($urandom % 2);
            wd  = 1'($urandom % 2);
            if (($urandom % 8) == 0) bl = 5'($urandom % 32);
            else bl = b16 ? 5'(2 * (1 + $urandom % 8)) : 5'(2 + $urandom % 15);
            run_txn(b16, wr, wd, fe, bl, 20'($urandom), 16'($urandom), int'($urandom % 3));
        end
        // R11 no drive during reads over the whole run
        chk(fights == 0, "R11 driver fights", 32'(fights), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule